// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits in the memory stage of a 32-bit integer core. It is purely combinational. It adapts between the full-width memory word and the narrower accesses that load and store instructions ask for.

On the load side it takes the width code, the two lowest address bits and the word returned by memory. It selects the byte or halfword the address points at and widens it to a full word, with either sign or zero fill. A full-word load passes through unchanged.

On the store side it takes the same width code, the low address bits and the source register value. It moves the low byte or halfword of the source into the addressed lane, clears every other bit, and raises one write strobe per byte that memory must update. Bytes whose strobe is low keep their old contents in memory. The load path and the store path are independent. Each has its own enable.

Top module: `lsu_lane_align`

## Requirements
- R1: Width code 3'b000 on a load (byte, signed) returns the byte at bits 8*a+7:8*a of the read word, where a is the address low pair, sign-extended from its bit 7.
- R2: Width code 3'b100 on a load (byte, unsigned) returns the same byte as R1 with zeros in bits 31:8.
- R3: Width code 3'b001 on a load (halfword, signed) returns bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1, sign-extended from the halfword's bit 15. Address bit 0 has no effect.
- R4: Width code 3'b101 on a load (halfword, unsigned) selects as in R3 and fills bits 31:16 with zeros.
- R5: Width code 3'b010 on a load returns the read word unchanged for every address low pair.
- R6: The load result is all zeros while the load enable is low, or when the width code is 3'b011, 3'b110 or 3'b111.
- R7: Width code 3'b000 on a store raises only strobe a (strobe bit i covers write bits 8*i+7:8*i). It places source bits 7:0 at bits 8*a+7:8*a, with zeros elsewhere.
- R8: Width code 3'b001 on a store raises strobes 1:0 (4'b0011) when address bit 1 is 0, and strobes 3:2 (4'b1100) when it is 1. Source bits 15:0 go to bits 15:0 or 31:16 respectively, with zeros elsewhere, and address bit 0 has no effect.
- R9: Width code 3'b010 on a store raises all four strobes and passes the source word unchanged.
- R10: While the store enable is low, or for any store width code other than 3'b000, 3'b001 and 3'b010, all strobes are low and the write word is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ld_en | input | 1 | A load is being completed this cycle |
| st_en | input | 1 | A store is being issued this cycle |
| width_code | input | 3 | Access width and signedness code (instruction funct3) |
| addr_lo | input | 2 | Lowest two bits of the byte address |
| rd_word | input | 32 | Word returned by memory |
| ld_result | output | 32 | Aligned and extended load value |
| st_src | input | 32 | Store source register value |
| wr_word | output | 32 | Lane-shifted write data |
| wr_strobe | output | 4 | Per-byte write enables, bit i for byte i |

## Verification
There is no register between any input and any output, so every result is due in the same cycle as the stimulus that produces it. The bench applies a new input vector just after a rising edge of its own pacing clock. It compares both outputs at the next falling edge, when the combinational paths have settled and no edge-ordering race remains. It sweeps every width code, address pair and enable combination across a set of data words chosen to stress the sign bit of each lane.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;

    typedef enum logic [2:0] {
        ACC_BYTE   = 3'b000,
        ACC_HALF   = 3'b001,
        ACC_WORD   = 3'b010,
        ACC_BYTE_U = 3'b100,
        ACC_HALF_U = 3'b101
    } acc_kind_e;

endpackage

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                         ld_en,
    input  logic [2:0]                   width_code,
    input  logic [$clog2(XLEN/8)-1:0]    addr_lo,
    input  logic [XLEN-1:0]              rd_word,
    output logic [XLEN-1:0]              ld_result
);
    localparam int unsigned NBYTES = XLEN / BYTE_W;
    localparam int unsigned NHALF  = NBYTES / 2;
    localparam int unsigned LANE_W = $clog2(NBYTES);

    logic [BYTE_W-1:0] byte_lane [NBYTES];
    logic [HALF_W-1:0] half_lane [NHALF];

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        assign byte_lane[gi] = rd_word[gi*BYTE_W +: BYTE_W];
    end

    for (genvar gh = 0; gh < NHALF; gh++) begin : g_half
        assign half_lane[gh] = rd_word[gh*HALF_W +: HALF_W];
    end

    logic [BYTE_W-1:0] pick_byte;
    logic [HALF_W-1:0] pick_half;

    assign pick_byte = byte_lane[addr_lo];
    assign pick_half = half_lane[addr_lo[LANE_W-1:1]];

    always_comb begin
        ld_result = '0;
        if (ld_en) begin
            unique case (width_code)
                ACC_BYTE:   ld_result = {{(XLEN-BYTE_W){pick_byte[BYTE_W-1]}}, pick_byte};
                ACC_BYTE_U: ld_result = {{(XLEN-BYTE_W){1'b0}}, pick_byte};
                ACC_HALF:   ld_result = {{(XLEN-HALF_W){pick_half[HALF_W-1]}}, pick_half};
                ACC_HALF_U: ld_result = {{(XLEN-HALF_W){1'b0}}, pick_half};
                ACC_WORD:   ld_result = rd_word;
                default:    ld_result = '0;
            endcase
        end
    end
endmodule

// File: rtl/lsu_store_place.sv
module lsu_store_place
    import lsu_lane_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                         st_en,
    input  logic [2:0]                   width_code,
    input  logic [$clog2(XLEN/8)-1:0]    addr_lo,
    input  logic [XLEN-1:0]              st_src,
    output logic [XLEN-1:0]              wr_word,
    output logic [XLEN/8-1:0]            wr_strobe
);
    localparam int unsigned NBYTES = XLEN / BYTE_W;
    localparam int unsigned LANE_W = $clog2(NBYTES);

    logic is_byte, is_half, is_word;

    always_comb begin
        is_byte = 1'b0;
        is_half = 1'b0;
        is_word = 1'b0;
        if (st_en) begin
            unique case (width_code)
                ACC_BYTE: is_byte = 1'b1;
                ACC_HALF: is_half = 1'b1;
                ACC_WORD: is_word = 1'b1;
                default:  ;
            endcase
        end
    end

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
        localparam logic [LANE_W-1:0] LANE_IDX = LANE_W'(gi);
        localparam int unsigned HALF_SRC = gi % 2;

        logic hit;
        logic [BYTE_W-1:0] lane_data;

        always_comb begin
            hit       = 1'b0;
            lane_data = '0;
            if (is_word) begin
                hit       = 1'b1;
                lane_data = st_src[gi*BYTE_W +: BYTE_W];
            end else if (is_half) begin
                hit       = (addr_lo[LANE_W-1:1] == LANE_IDX[LANE_W-1:1]);
                lane_data = st_src[HALF_SRC*BYTE_W +: BYTE_W];
            end else if (is_byte) begin
                hit       = (addr_lo == LANE_IDX);
                lane_data = st_src[BYTE_W-1:0];
            end
        end

        assign wr_strobe[gi]                = hit;
        assign wr_word[gi*BYTE_W +: BYTE_W] = hit ? lane_data : '0;
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                         ld_en,
    input  logic                         st_en,
    input  logic [2:0]                   width_code,
    input  logic [$clog2(XLEN/8)-1:0]    addr_lo,
    input  logic [XLEN-1:0]              rd_word,
    output logic [XLEN-1:0]              ld_result,
    input  logic [XLEN-1:0]              st_src,
    output logic [XLEN-1:0]              wr_word,
    output logic [XLEN/8-1:0]            wr_strobe
);
    lsu_load_extract #(.XLEN(XLEN)) u_load (
        .ld_en      (ld_en),
        .width_code (width_code),
        .addr_lo    (addr_lo),
        .rd_word    (rd_word),
        .ld_result  (ld_result)
    );

    lsu_store_place #(.XLEN(XLEN)) u_store (
        .st_en      (st_en),
        .width_code (width_code),
        .addr_lo    (addr_lo),
        .st_src     (st_src),
        .wr_word    (wr_word),
        .wr_strobe  (wr_strobe)
    );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic                         ld_en,
    input logic                         st_en,
    input logic [2:0]                   width_code,
    input logic [$clog2(XLEN/8)-1:0]    addr_lo,
    input logic [XLEN-1:0]              rd_word,
    input logic [XLEN-1:0]              ld_result,
    input logic [XLEN-1:0]              st_src,
    input logic [XLEN-1:0]              wr_word,
    input logic [XLEN/8-1:0]            wr_strobe
);
    logic known;
    assign known = !$isunknown({ld_en, st_en, width_code, addr_lo, rd_word, st_src});

    always_comb begin
        if (known) begin
            if (ld_en && width_code == 3'b000)
                AST_LB_SIGN_FILL: assert (ld_result[XLEN-1:8] == {(XLEN-8){ld_result[7]}}); // R1
            if (ld_en && width_code == 3'b100)
                AST_LBU_ZERO_FILL: assert (ld_result[XLEN-1:8] == '0); // R2
            if (ld_en && width_code == 3'b001)
                AST_LH_SIGN_FILL: assert (ld_result[XLEN-1:16] == {(XLEN-16){ld_result[15]}}); // R3
            if (ld_en && width_code == 3'b101)
                AST_LHU_ZERO_FILL: assert (ld_result[XLEN-1:16] == '0); // R4
            if (ld_en && width_code == 3'b010)
                AST_LW_PASS: assert (ld_result == rd_word); // R5
            if (!ld_en)
                AST_LD_IDLE_ZERO: assert (ld_result == '0); // R6
            if (st_en && width_code == 3'b000)
                AST_SB_ONE_LANE: assert ($countones(wr_strobe) == 1); // R7
            if (st_en && width_code == 3'b001)
                AST_SH_PAIR: assert (wr_strobe == 4'b0011 || wr_strobe == 4'b1100); // R8
            if (st_en && width_code == 3'b010)
                AST_SW_ALL: assert (wr_strobe == '1 && wr_word == st_src); // R9
            if (!st_en)
                AST_ST_IDLE_QUIET: assert (wr_strobe == '0 && wr_word == '0); // R10
        end
    end
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.XLEN(XLEN)) u_chk (
    .ld_en      (ld_en),
    .st_en      (st_en),
    .width_code (width_code),
    .addr_lo    (addr_lo),
    .rd_word    (rd_word),
    .ld_result  (ld_result),
    .st_src     (st_src),
    .wr_word    (wr_word),
    .wr_strobe  (wr_strobe)
);

// File: tb/sim_lsu_lane_align.sv
`timescale 1ns/1ps
module sim_lsu_lane_align;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        ld_en, st_en;
    logic [2:0]  width_code;
    logic [1:0]  addr_lo;
    logic [31:0] rd_word, st_src;
    logic [31:0] ld_result, wr_word;
    logic [3:0]  wr_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    lsu_lane_align u0 (
        .ld_en(ld_en), .st_en(st_en), .width_code(width_code), .addr_lo(addr_lo),
        .rd_word(rd_word), .ld_result(ld_result), .st_src(st_src),
        .wr_word(wr_word), .wr_strobe(wr_strobe)
    );

    function automatic logic [31:0] model_ld(input logic en, input logic [2:0] f,
                                             input logic [1:0] a, input logic [31:0] w);
        logic [31:0] b, h;
        b = (w >> (8 * a)) & 32'hFF;
        h = (w >> (16 * a[1])) & 32'hFFFF;
        if (!en) return 32'h0;
        case (f)
            3'b000: return (b >= 32'h80) ? b + 32'hFFFF_FF00 : b;
            3'b100: return b;
            3'b001: return (h >= 32'h8000) ? h + 32'hFFFF_0000 : h;
            3'b101: return h;
            3'b010: return w;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] model_stb(input logic en, input logic [2:0] f, input logic [1:0] a);
        if (!en) return 4'h0;
        case (f)
            3'b000: return 4'(1 << a);
            3'b001: return a[1] ? 4'b1100 : 4'b0011;
            3'b010: return 4'b1111;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_wd(input logic en, input logic [2:0] f,
                                             input logic [1:0] a, input logic [31:0] s);
        if (!en) return 32'h0;
        case (f)
            3'b000: return (s & 32'hFF) << (8 * a);
            3'b001: return (s & 32'hFFFF) << (16 * a[1]);
            3'b010: return s;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string ld_tag(input logic en, input logic [2:0] f);
        if (!en) return "R6";
        case (f)
            3'b000: return "R1";
            3'b100: return "R2";
            3'b001: return "R3";
            3'b101: return "R4";
            3'b010: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic string st_tag(input logic en, input logic [2:0] f);
        if (!en) return "R10";
        case (f)
            3'b000: return "R7";
            3'b001: return "R8";
            3'b010: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (code %b addr %0d ld_en %b st_en %b)",
                     req, what, act, exp, width_code, addr_lo, ld_en, st_en);
        end
    endtask

    function automatic logic [31:0] pattern(input int k, input logic [31:0] seed);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8080_8080;
            3: return 32'h7F7F_7F7F;
            4: return 32'h8000_7FFF;
            5: return 32'h7FFF_8000;
            6: return 32'h0123_80FE;
            default: return seed;
        endcase
    endfunction

    initial begin
        logic [31:0] seed;
        seed = 32'h1F2E_3D4C;
        ld_en = 1'b0; st_en = 1'b0; width_code = 3'b000; addr_lo = 2'd0;
        rd_word = 32'h0; st_src = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        rd_word = 32'hDEAD_BEEF; st_src = 32'hCAFE_F00D;
        @(negedge clk);
        check32("R6", "idle load result", ld_result, 32'h0);
        check32("R10", "idle strobes", {28'h0, wr_strobe}, 32'h0);
        check32("R10", "idle write word", wr_word, 32'h0);

        for (int p = 0; p < 16; p++) begin
            for (int en = 0; en < 4; en++) begin
                for (int f = 0; f < 8; f++) begin
                    for (int a = 0; a < 4; a++) begin
                        @(posedge clk);
                        seed = seed ^ (seed << 13);
                        seed = seed ^ (seed >> 17);
                        seed = seed ^ (seed << 5);
                        ld_en      = en[0];
                        st_en      = en[1];
                        width_code = 3'(f);
                        addr_lo    = 2'(a);
                        rd_word    = pattern(p, seed);
                        st_src     = pattern(p, ~seed);
                        @(negedge clk);
                        check32(ld_tag(ld_en, width_code), "load result", ld_result,
                                model_ld(ld_en, width_code, addr_lo, rd_word));
                        check32(st_tag(st_en, width_code), "strobes", {28'h0, wr_strobe},
                                {28'h0, model_stb(st_en, width_code, addr_lo)});
                        check32(st_tag(st_en, width_code), "write word", wr_word,
                                model_wd(st_en, width_code, addr_lo, st_src));
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule